// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a successive-approximation analog-to-digital converter with eight multiplexed inputs. Software drives it through three byte-wide registers, picked by a two-bit address. The control/status register enables the converter, starts a conversion, reports completion, connects the inputs and picks the channel. The mode register picks the resolution and the conversion clock, and it also returns the low result nibble. The third register returns the upper eight result bits.

Once started, the sequencer spends one conversion-clock step tracking the input. It then resolves one bit per step, from the most significant bit down. In each step it drives a trial code to the external DAC and reads back a single comparator bit. The conversion clock is either the system clock divided by four or an external high-speed oscillator tick. The oscillator tick only counts in normal power mode. The result is loaded and the completion flag is raised in the same cycle that the start bit clears itself. No data path here streams: the result is read as register contents, so every pin is plain control or status, with no valid/ready handshake and no back-pressure.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control register (address 1) reads 0x00, the mode register (address 3) reads 0x00, and `ain_sel` is all zero.
- R2: Control bits 2..0 pick the channel (code k selects input k), and control bit 4 connects the inputs. `ain_sel` is one-hot with bit k set when bit 4 is 1, and all zero when bit 4 is 0, in which case the conversion result is 0.
- R3: A write to control with bit 7 (enable) and bit 6 (start) both 1 starts a conversion. With bit 7 at 0, start reads back as written, but no conversion runs, bit 5 stays 0 and the result is unchanged.
- R4: At completion, control bit 5 (end of conversion) becomes 1, control bit 6 clears itself, and the result registers load the new value.
- R5: A conversion takes one sample step plus N compare steps (N = 8 or 12). With every oscillator tick present, bit 5 reads 1 after exactly N+2 clock edges, counted from the edge that accepts the start write.
- R6: Mode bit 5 = 1 selects 12 bits. The high register (address 2) then holds result bits 11..4 and mode bits 3..0 hold result bits 3..0.
- R7: Mode bit 5 = 0 selects 8 bits. The high register then holds the 8-bit result and mode bits 3..0 read 0.
- R8: Writing control with bit 6 = 0 during a conversion aborts it. Bit 5 stays 0 and the result registers are unchanged.
- R9: Mode bit 6 = 0 steps the sequencer once every 4 clocks, so bit 5 rises between 4N+2 and 4N+5 edges after the start. Mode bit 6 = 1 steps it on each `osc_tick`.
- R10: With mode bit 6 = 1 and `slow_mode` high, the sequencer freezes, with a stable `dac_code` and no completion, and it resumes when `slow_mode` falls. The divided clock keeps stepping in slow mode.
- R11: Mode bits 7 and 4 and control bit 3 always read 0. Writes to the high register and to the result bits of the mode register have no effect.
- R12: A write that sets the start bit clears bit 5 in the same edge.
- R13: The comparator input `cmp_hi` = 1 means the selected input is at or above `dac_code`. The trial bit is kept when it is 1 and cleared when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (also the base of the divided conversion clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 1 control, 2 high result, 3 mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| slow_mode | input | 1 | Low-power mode: the oscillator tick is ignored |
| osc_tick | input | 1 | One-cycle pulse from the high-speed oscillator, synchronous to `clk` |
| ain_sel | output | 8 | One-hot analog input switch enables |
| sample | output | 1 | Track phase of the sample-and-hold |
| dac_code | output | 12 | Trial code for the DAC |
| cmp_hi | input | 1 | Comparator: input at or above the DAC level |

## Verification
The assertions assume that register writes are the only way software changes the enable, start and clock-select state. They also assume that `osc_tick` and `slow_mode` are synchronous to `clk`, so a freeze in slow mode can be checked as a stable `dac_code` over any cycle without a write. The bench drives every input at the falling edge and issues writes only through single-cycle strobes. It changes `slow_mode` only between edges, so these premises always hold. The comparator is modelled from the DAC code and a stored value per channel, with the unselected channels set to the complement of the selected value.

// File: rtl/sar_adc_pkg.sv
`timescale 1ns/1ps
package sar_adc_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_HIGH = 2'd2;
  localparam logic [1:0] ADDR_MODE = 2'd3;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_CONV   = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic       en;
    logic       start;
    logic       eoc;
    logic       gin;
    logic [2:0] chan;
  } ctrl_t;
endpackage

// File: rtl/sar_tick_gen.sv
`timescale 1ns/1ps
module sar_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_sel,
  input  logic slow_mode,
  input  logic osc_tick,
  output logic step
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] div_cnt;
  logic          div_tick;

  assign div_tick = (div_cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else if (div_tick) div_cnt <= '0;
    else div_cnt <= div_cnt + 1'b1;
  end

  // oscillator steps are only honoured in normal power mode
  assign step = clk_sel ? (osc_tick & ~slow_mode) : div_tick;
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             step,
  input  logic             res_long,
  input  logic             cmp_hi,
  output logic             busy,
  output logic             sampling,
  output logic [RES_W-1:0] dac_code,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] SHORT_LSB = IDX_W'(RES_W - SHORT_W);

  seq_state_t       state;
  logic [RES_W-1:0] approx;
  logic [RES_W-1:0] kept;
  logic [RES_W-1:0] trial_nxt;
  logic [IDX_W-1:0] idx;
  logic             long_q;
  logic [IDX_W-1:0] stop_idx;
  logic             last_bit;

  assign stop_idx = long_q ? '0 : SHORT_LSB;
  assign last_bit = (idx == stop_idx);

  always_comb begin
    kept      = approx;
    kept[idx] = cmp_hi;
    trial_nxt = kept;
    if (idx != '0) trial_nxt[idx - 1'b1] = 1'b1;
  end

  assign busy     = (state != SEQ_IDLE);
  assign sampling = (state == SEQ_SAMPLE);
  assign dac_code = approx;
  assign done     = go && step && (state == SEQ_CONV) && last_bit;
  assign result   = kept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      approx <= '0;
      idx    <= '0;
      long_q <= 1'b0;
    end else if (!go) begin
      state  <= SEQ_IDLE;
      approx <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          state  <= SEQ_SAMPLE;
          long_q <= res_long;
          approx <= '0;
        end
        SEQ_SAMPLE: if (step) begin
          state  <= SEQ_CONV;
          approx <= {1'b1, {(RES_W-1){1'b0}}};
          idx    <= TOP_IDX;
        end
        SEQ_CONV: if (step) begin
          if (last_bit) begin
            state  <= SEQ_IDLE;
            approx <= '0;
          end else begin
            approx <= trial_nxt;
            idx    <= idx - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_chan_dec.sv
`timescale 1ns/1ps
module sar_chan_dec #(
  parameter int NCH = 8,
  parameter int CH_W = 3
) (
  input  logic            gin,
  input  logic [CH_W-1:0] chan,
  output logic [NCH-1:0]  ain_sel
);
  for (genvar i = 0; i < NCH; i++) begin : g_sw
    assign ain_sel[i] = gin && (chan == CH_W'(i));
  end
endmodule

// File: rtl/sar_regs.sv
`timescale 1ns/1ps
module sar_regs
  import sar_adc_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             done,
  input  logic [RES_W-1:0] res_in,
  output ctrl_t            ctrl,
  output logic             clk_sel,
  output logic             res_long
);
  localparam int LOW_W = RES_W - REG_W;

  logic [RES_W-1:0] result_q;
  logic             unused_wbit;

  assign unused_wbit = bus_wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      clk_sel  <= 1'b0;
      res_long <= 1'b0;
      result_q <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_CTRL) begin
        ctrl.en    <= bus_wdata[7];
        ctrl.start <= bus_wdata[6];
        ctrl.eoc   <= bus_wdata[6] ? 1'b0 : bus_wdata[5];
        ctrl.gin   <= bus_wdata[4];
        ctrl.chan  <= bus_wdata[2:0];
      end
      if (bus_wr && bus_addr == ADDR_MODE) begin
        clk_sel  <= bus_wdata[6];
        res_long <= bus_wdata[5];
      end
      // completion outranks a same-cycle software write
      if (done) begin
        ctrl.start <= 1'b0;
        ctrl.eoc   <= 1'b1;
        result_q   <= res_in;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {ctrl.en, ctrl.start, ctrl.eoc, ctrl.gin, 1'b0, ctrl.chan};
      ADDR_HIGH: bus_rdata = result_q[RES_W-1 -: REG_W];
      ADDR_MODE: bus_rdata = {1'b0, clk_sel, res_long, {(REG_W-3-LOW_W){1'b0}},
                              result_q[LOW_W-1:0]};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8,
  parameter int NCH     = 8,
  parameter int DIV     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             slow_mode,
  input  logic             osc_tick,
  output logic [NCH-1:0]   ain_sel,
  output logic             sample,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_hi
);
  localparam int CH_W = $clog2(NCH);

  ctrl_t            ctrl;
  logic             clk_sel;
  logic             res_long;
  logic             step;
  logic             go;
  logic             busy;
  logic             done;
  logic [RES_W-1:0] res_new;

  assign go = ctrl.en && ctrl.start;

  sar_regs #(.RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
    .res_in(res_new), .ctrl(ctrl), .clk_sel(clk_sel), .res_long(res_long)
  );

  sar_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .slow_mode(slow_mode),
    .osc_tick(osc_tick), .step(step)
  );

  sar_seq #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .step(step), .res_long(res_long),
    .cmp_hi(cmp_hi), .busy(busy), .sampling(sample), .dac_code(dac_code),
    .done(done), .result(res_new)
  );

  sar_chan_dec #(.NCH(NCH), .CH_W(CH_W)) u_dec (
    .gin(ctrl.gin), .chan(ctrl.chan[CH_W-1:0]), .ain_sel(ain_sel)
  );
endmodule

// File: rtl/sar_adc_chk.sv
`timescale 1ns/1ps
module sar_adc_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             slow_mode,
  input logic             clk_sel,
  input logic             en,
  input logic             start,
  input logic             eoc,
  input logic             busy,
  input logic [RES_W-1:0] dac_code
);
  AST_RUN_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en && start)) else $error("run without enable"); // R3

  AST_EOC_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(busy)) else $error("eoc without run"); // R4

  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> !start) else $error("start not cleared"); // R4

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> !busy) else $error("abort ignored"); // R8

  AST_SLOW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clk_sel && slow_mode && !bus_wr) |=> $stable(dac_code))
    else $error("advanced in slow mode"); // R10
endmodule

bind sar_adc_ctrl sar_adc_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .slow_mode(slow_mode),
  .clk_sel(clk_sel), .en(ctrl.en), .start(ctrl.start), .eoc(ctrl.eoc),
  .busy(busy), .dac_code(dac_code)
);

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;
  localparam logic [1:0] A_CTRL = 2'd1, A_HIGH = 2'd2, A_MODE = 2'd3;
  localparam int NV = 8;
  // [17] 12-bit, [16] osc clock, [15] inputs on, [14:12] channel, [11:0] input level
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 3'd0, 12'hABC},
    {1'b0, 1'b1, 1'b1, 3'd3, 12'h5A7},
    {1'b1, 1'b0, 1'b1, 3'd7, 12'hFFF},
    {1'b1, 1'b1, 1'b1, 3'd5, 12'h000},
    {1'b0, 1'b0, 1'b1, 3'd1, 12'h801},
    {1'b1, 1'b1, 1'b0, 3'd2, 12'h777},
    {1'b1, 1'b1, 1'b1, 3'd6, 12'h001},
    {1'b0, 1'b1, 1'b1, 3'd4, 12'h800}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        slow_mode = 1'b0;
  logic        osc_tick = 1'b1;
  logic [7:0]  ain_sel;
  logic        sample;
  logic [11:0] dac_code;
  logic        cmp_hi;
  logic [11:0] ain_val [8];
  logic [11:0] vin_sel;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always_comb begin
    vin_sel = 12'h000;
    for (int i = 0; i < 8; i++) if (ain_sel[i]) vin_sel = ain_val[i];
    cmp_hi = (vin_sel >= dac_code);   // R13 comparator model
  end

  sar_adc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slow_mode(slow_mode),
    .osc_tick(osc_tick), .ain_sel(ain_sel), .sample(sample),
    .dac_code(dac_code), .cmp_hi(cmp_hi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_eoc(output int d);
    logic [7:0] r;
    d = 0;
    do begin
      @(negedge clk);
      d++;
      rd_reg(A_CTRL, r);
    end while (!r[5] && d < 2000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic [11:0] exp_res, held;
    int d, n;
    for (int i = 0; i < 8; i++) ain_val[i] = 12'h000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(A_CTRL, r); check("R1 ctrl reset", r, 8'h00);
    rd_reg(A_MODE, r); check("R1 mode reset", r, 8'h00);
    check("R1 ain_sel reset", ain_sel, 8'h00);

    // table of conversions
    for (int v = 0; v < NV; v++) begin
      logic        l12, osc, gin;
      logic [2:0]  ch;
      logic [11:0] vin;
      {l12, osc, gin, ch, vin} = VEC[v];
      for (int i = 0; i < 8; i++) ain_val[i] = vin ^ 12'hFFF;
      ain_val[ch] = vin;
      n = l12 ? 12 : 8;
      exp_res = !gin ? 12'h000 : (l12 ? vin : {vin[11:4], 4'h0});
      wr_reg(A_MODE, {1'b0, osc, l12, 5'b0});
      bus_addr = A_CTRL; bus_wdata = {2'b11, 1'b0, gin, 1'b0, ch}; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rd_reg(A_CTRL, r);
      check("R12 eoc cleared by start", r[5], 1'b0);
      check("R3 start held while running", r[6], 1'b1);
      check("R2 ain_sel", ain_sel, gin ? (8'h01 << ch) : 8'h00);
      wait_eoc(d);
      if (osc) check("R5 step count osc", d, n + 2);
      else check("R9 step count divided", (d >= 4*n+2 && d <= 4*n+5), 1'b1);
      rd_reg(A_CTRL, r);
      check("R4 start self-cleared", r[6], 1'b0);
      rd_reg(A_HIGH, r);
      check(l12 ? "R6 high result" : "R7 high result", r, exp_res[11:4]);
      rd_reg(A_MODE, r);
      check(l12 ? "R6 low nibble" : "R7 low nibble zero", r,
            {1'b0, osc, l12, 1'b0, exp_res[3:0]});
    end

    // R3: start without enable does nothing
    held = 12'h800;
    wr_reg(A_CTRL, 8'h50);
    repeat (60) @(negedge clk);
    rd_reg(A_CTRL, r); check("R3 no enable ctrl", r, 8'h50);
    rd_reg(A_HIGH, r); check("R3 no enable result", r, held[11:4]);

    // R8: abort mid conversion
    for (int i = 0; i < 8; i++) ain_val[i] = 12'h3C5;
    wr_reg(A_MODE, 8'h60);
    wr_reg(A_CTRL, 8'hD0);
    repeat (5) @(negedge clk);
    wr_reg(A_CTRL, 8'h90);
    repeat (30) @(negedge clk);
    rd_reg(A_CTRL, r); check("R8 abort no eoc", r, 8'h90);
    rd_reg(A_HIGH, r); check("R8 abort result kept", r, held[11:4]);

    // R10: oscillator clock frozen in slow mode
    ain_val[0] = 12'h9E3;
    wr_reg(A_CTRL, 8'hD0);
    repeat (3) @(negedge clk);
    slow_mode = 1'b1;
    @(negedge clk);
    held = dac_code;
    repeat (40) @(negedge clk);
    check("R10 dac frozen", dac_code, held);
    rd_reg(A_CTRL, r); check("R10 no completion while frozen", r[5], 1'b0);
    slow_mode = 1'b0;
    wait_eoc(d);
    rd_reg(A_HIGH, r); check("R10 result after resume", r, 8'h9E);
    rd_reg(A_MODE, r); check("R10 low nibble after resume", r, 8'h63);

    // R10: divided clock keeps running in slow mode
    ain_val[0] = 12'h2B6;
    wr_reg(A_MODE, 8'h20);
    slow_mode = 1'b1;
    wr_reg(A_CTRL, 8'hD0);
    wait_eoc(d);
    check("R10 divided runs in slow", (d <= 4*12+6), 1'b1);
    rd_reg(A_HIGH, r); check("R10 divided result", r, 8'h2B);
    slow_mode = 1'b0;

    // R11: reserved and read-only bits
    wr_reg(A_MODE, 8'hFF);
    rd_reg(A_MODE, r); check("R11 mode reserved and result bits", r, 8'h66);
    wr_reg(A_HIGH, 8'h55);
    rd_reg(A_HIGH, r); check("R11 high read-only", r, 8'h2B);
    wr_reg(A_CTRL, 8'h08);
    rd_reg(A_CTRL, r); check("R11 ctrl bit 3", r, 8'h00);
    check("R2 inputs off", ain_sel, 8'h00);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule